// File: doc/BRIEF.md
# Error Status and Logging Register File

This block collects one-cycle error pulses from the link and transaction layers and keeps them in software-visible registers. There are two banks of sticky status bits. Twelve uncorrectable sources each have a mask bit and a severity bit. Six correctable sources each have a mask bit. A pointer records where the first uncorrectable error landed. A four-flag device summary register gives a condensed view of all error activity.

A masked source is dropped entirely: it is neither recorded nor reported. An unmasked source sets its status bit and raises a one-cycle message-request pulse for its class. The classes are correctable, non-fatal and fatal, and an uncorrectable error picks between non-fatal and fatal through its severity bit.

Software reads and writes the seven registers through a flat port with address, write data and write enable. Read data is combinational from the address. All status bits and summary flags clear when software writes a 1 to them.

The reset input asserts asynchronously. Its release passes through a two-stage synchronizer before the registers leave reset.

Top module: `err_log_regs`

## Requirements
- R1: After reset, every status register, the uncorrectable mask, the severity register, the pointer and the device summary read 0, and the correctable mask reads 32'h0000_2000 (only the advisory bit is set).
- R2: Uncorrectable sources 0..11 occupy bits 4, 5, 12, 13, 14, 15, 16, 17, 18, 19, 20 and 21 of their registers. Correctable sources 0..5 occupy bits 0, 6, 7, 8, 12 and 13. Every other bit reads 0.
- R3: A status bit sets on an unmasked pulse of its source and stays set until software writes 1 to it (address 0 uncorrectable, address 3 correctable). Writing 0 has no effect. A new pulse in the same cycle as a clear leaves the bit set.
- R4: A source whose mask bit is 1 sets no status bit, no summary flag and no message pulse.
- R5: An unmasked uncorrectable error produces a fatal message when its severity bit (address 2) is 1, and a non-fatal message when it is 0.
- R6: Each message output is registered. It pulses high for exactly one cycle, in the cycle after any clock edge that saw at least one new unmasked error of its class, no matter how many such errors arrived.
- R7: The pointer, in bits 4:0 of address 5, loads the bit position of the lowest-indexed new unmasked uncorrectable error. It loads only when no unmasked uncorrectable status bit is already set, and otherwise holds.
- R8: The device summary at address 6 has these flags: bit 0 correctable, bit 1 non-fatal, bit 2 fatal, bit 3 unsupported request (uncorrectable source 10). Each sets on a new unmasked error of its kind and clears when software writes 1 to it.
- R9: Address 1 holds the uncorrectable mask and address 4 the correctable mask. Only the implemented bits of address 1, 2 and 4 are writable. Writes to address 5 and address 7 have no effect, and address 7 reads 0.
- R10: The registers stay in reset for the first two rising clock edges after the reset input is released, so an error pulse at those edges is not recorded.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| unc_err_i | input | N_UNC | One-cycle uncorrectable error pulses, one per source |
| cor_err_i | input | N_COR | One-cycle correctable error pulses, one per source |
| reg_addr_i | input | AW | Register address |
| reg_wdata_i | input | DW | Register write data |
| reg_we_i | input | 1 | Register write enable |
| reg_rdata_o | output | DW | Register read data, combinational from the address |
| msg_cor_o | output | 1 | Correctable message request pulse |
| msg_nonfatal_o | output | 1 | Non-fatal message request pulse |
| msg_fatal_o | output | 1 | Fatal message request pulse |

## Verification
The bench builds the block with its default parameters: twelve uncorrectable sources, six correctable sources and a 32-bit data path. With these values the full fixed bit-position map is in play. So are the pointer's largest position (21) and the unsupported-request summary flag tied to source 10.

A behavioural model follows every register and message output on every cycle. Directed steps cover same-cycle set and clear, simultaneous errors competing for the pointer, and the severity split. A long randomized stretch then mixes sparse pulses with writes to every address, including the read-only ones. A reset applied mid-run checks both the asynchronous assertion and the delayed release.

// File: rtl/errlog_pkg.sv
package errlog_pkg;

  localparam int ADDR_USTAT  = 0;
  localparam int ADDR_UMASK  = 1;
  localparam int ADDR_USEV   = 2;
  localparam int ADDR_CSTAT  = 3;
  localparam int ADDR_CMASK  = 4;
  localparam int ADDR_CAPCTL = 5;
  localparam int ADDR_DEVSTA = 6;

  localparam int DEV_W      = 4;
  localparam int DEV_COR    = 0;
  localparam int DEV_NF     = 1;
  localparam int DEV_FATAL  = 2;
  localparam int DEV_UR     = 3;
  localparam int UR_SRC_IDX = 10;

  // bit position of uncorrectable source i inside its 32-bit register
  function automatic int unsigned unc_pos(int unsigned i);
    return (i < 2) ? (4 + i) : (10 + i);
  endfunction

  // bit position of correctable source i inside its 32-bit register
  function automatic int unsigned cor_pos(int unsigned i);
    if (i == 0) return 0;
    else if (i < 4) return i + 5;
    else return i + 8;
  endfunction

endpackage

// File: rtl/errlog_rst_sync.sv
module errlog_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;

endmodule

// File: rtl/errlog_bank.sv
module errlog_bank #(
  parameter int          N        = 12,
  parameter logic [N-1:0] MASK_RST = '0,
  parameter bit          HAS_SEV  = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] err_i,
  input  logic [N-1:0] clr_i,
  input  logic         mask_we_i,
  input  logic         sev_we_i,
  input  logic [N-1:0] wval_i,
  output logic [N-1:0] stat_o,
  output logic [N-1:0] mask_o,
  output logic [N-1:0] sev_o,
  output logic [N-1:0] new_o
);

  logic [N-1:0] stat_q, stat_d;
  logic [N-1:0] mask_q, mask_d;
  logic         stat_en;

  always_comb begin
    new_o   = err_i & ~mask_q;
    stat_en = (|new_o) || (|clr_i);
    stat_d  = (stat_q & ~clr_i) | new_o;
    mask_d  = wval_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (stat_en) begin
      stat_q <= stat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= MASK_RST;
    end else if (mask_we_i) begin
      mask_q <= mask_d;
    end
  end

  generate
    if (HAS_SEV) begin : g_sev
      logic [N-1:0] sev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sev_q <= '0;
        end else if (sev_we_i) begin
          sev_q <= wval_i;
        end
      end
      assign sev_o = sev_q;
    end else begin : g_nosev
      assign sev_o = '0;
    end
  endgenerate

  assign stat_o = stat_q;
  assign mask_o = mask_q;

  generate
    for (genvar i = 0; i < N; i++) begin : g_chk
      // R3
      sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[i] && !clr_i[i]) |=> stat_q[i]);
      // R4
      masked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_q[i] && mask_q[i] && err_i[i]) |=> !stat_q[i]);
    end
  endgenerate

endmodule

// File: rtl/errlog_first_ptr.sv
module errlog_first_ptr #(
  parameter int N  = 12,
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  stat_i,
  input  logic [N-1:0]  mask_i,
  input  logic [N-1:0]  new_i,
  output logic [PW-1:0] ptr_o
);

  import errlog_pkg::*;

  logic [PW-1:0] ptr_q, ptr_d;
  logic          armed, load;

  always_comb begin
    armed = ~|(stat_i & ~mask_i);
    load  = armed && (|new_i);
    ptr_d = ptr_q;
    for (int i = N - 1; i >= 0; i--) begin
      if (new_i[i]) ptr_d = PW'(unc_pos(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (load) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr_o = ptr_q;

  // R7
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed) |=> $stable(ptr_q));

endmodule

// File: rtl/err_log_regs.sv
module err_log_regs
  import errlog_pkg::*;
#(
  parameter int N_UNC = 12,
  parameter int N_COR = 6,
  parameter int DW    = 32,
  parameter int AW    = 3,
  parameter int PTR_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_UNC-1:0] unc_err_i,
  input  logic [N_COR-1:0] cor_err_i,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  input  logic             reg_we_i,
  output logic [DW-1:0]    reg_rdata_o,
  output logic             msg_cor_o,
  output logic             msg_nonfatal_o,
  output logic             msg_fatal_o
);

  localparam int POSW = $clog2(DW);
  localparam logic [N_COR-1:0] COR_MASK_RST = N_COR'(1) << (N_COR - 1);

  logic rst_s_n;

  errlog_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  // write decode
  logic we_ustat, we_umask, we_usev, we_cstat, we_cmask, we_dev;
  always_comb begin
    we_ustat = reg_we_i && (reg_addr_i == AW'(ADDR_USTAT));
    we_umask = reg_we_i && (reg_addr_i == AW'(ADDR_UMASK));
    we_usev  = reg_we_i && (reg_addr_i == AW'(ADDR_USEV));
    we_cstat = reg_we_i && (reg_addr_i == AW'(ADDR_CSTAT));
    we_cmask = reg_we_i && (reg_addr_i == AW'(ADDR_CMASK));
    we_dev   = reg_we_i && (reg_addr_i == AW'(ADDR_DEVSTA));
  end

  // write data unpacked to compact source order
  logic [N_UNC-1:0] unc_wv;
  logic [N_COR-1:0] cor_wv;
  generate
    for (genvar i = 0; i < N_UNC; i++) begin : g_uw
      assign unc_wv[i] = reg_wdata_i[POSW'(unc_pos(i))];
    end
    for (genvar j = 0; j < N_COR; j++) begin : g_cw
      assign cor_wv[j] = reg_wdata_i[POSW'(cor_pos(j))];
    end
  endgenerate

  logic [N_UNC-1:0] unc_stat, unc_mask, unc_sev, unc_new;
  logic [N_COR-1:0] cor_stat, cor_mask, cor_sev, cor_new;

  errlog_bank #(.N(N_UNC), .MASK_RST('0), .HAS_SEV(1'b1)) u_unc (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .err_i     (unc_err_i),
    .clr_i     (we_ustat ? unc_wv : '0),
    .mask_we_i (we_umask),
    .sev_we_i  (we_usev),
    .wval_i    (unc_wv),
    .stat_o    (unc_stat),
    .mask_o    (unc_mask),
    .sev_o     (unc_sev),
    .new_o     (unc_new)
  );

  errlog_bank #(.N(N_COR), .MASK_RST(COR_MASK_RST), .HAS_SEV(1'b0)) u_cor (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .err_i     (cor_err_i),
    .clr_i     (we_cstat ? cor_wv : '0),
    .mask_we_i (we_cmask),
    .sev_we_i  (1'b0),
    .wval_i    (cor_wv),
    .stat_o    (cor_stat),
    .mask_o    (cor_mask),
    .sev_o     (cor_sev),
    .new_o     (cor_new)
  );

  logic [PTR_W-1:0] first_ptr;

  errlog_first_ptr #(.N(N_UNC), .PW(PTR_W)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .stat_i (unc_stat),
    .mask_i (unc_mask),
    .new_i  (unc_new),
    .ptr_o  (first_ptr)
  );

  // class detection
  logic hit_cor, hit_nf, hit_fatal, hit_ur;
  always_comb begin
    hit_cor   = |cor_new;
    hit_nf    = |(unc_new & ~unc_sev);
    hit_fatal = |(unc_new & unc_sev);
    hit_ur    = unc_new[UR_SRC_IDX];
  end

  // device summary
  logic [DEV_W-1:0] dev_q, dev_d, dev_set, dev_clr;
  logic             dev_en;
  always_comb begin
    dev_set            = '0;
    dev_set[DEV_COR]   = hit_cor;
    dev_set[DEV_NF]    = hit_nf;
    dev_set[DEV_FATAL] = hit_fatal;
    dev_set[DEV_UR]    = hit_ur;
    dev_clr            = we_dev ? reg_wdata_i[DEV_W-1:0] : '0;
    dev_en             = (|dev_set) || (|dev_clr);
    dev_d              = (dev_q & ~dev_clr) | dev_set;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      dev_q <= '0;
    end else if (dev_en) begin
      dev_q <= dev_d;
    end
  end

  // message requests
  logic msg_cor_q, msg_nf_q, msg_fatal_q;
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      msg_cor_q   <= 1'b0;
      msg_nf_q    <= 1'b0;
      msg_fatal_q <= 1'b0;
    end else begin
      msg_cor_q   <= hit_cor;
      msg_nf_q    <= hit_nf;
      msg_fatal_q <= hit_fatal;
    end
  end

  assign msg_cor_o      = msg_cor_q;
  assign msg_nonfatal_o = msg_nf_q;
  assign msg_fatal_o    = msg_fatal_q;

  // read path
  logic [DW-1:0] ustat_w, umask_w, usev_w, cstat_w, cmask_w;
  always_comb begin
    ustat_w = '0;
    umask_w = '0;
    usev_w  = '0;
    cstat_w = '0;
    cmask_w = '0;
    for (int i = 0; i < N_UNC; i++) begin
      ustat_w[POSW'(unc_pos(i))] = unc_stat[i];
      umask_w[POSW'(unc_pos(i))] = unc_mask[i];
      usev_w[POSW'(unc_pos(i))]  = unc_sev[i];
    end
    for (int j = 0; j < N_COR; j++) begin
      cstat_w[POSW'(cor_pos(j))] = cor_stat[j];
      cmask_w[POSW'(cor_pos(j))] = cor_mask[j];
    end
  end

  always_comb begin
    case (reg_addr_i)
      AW'(ADDR_USTAT):  reg_rdata_o = ustat_w;
      AW'(ADDR_UMASK):  reg_rdata_o = umask_w;
      AW'(ADDR_USEV):   reg_rdata_o = usev_w;
      AW'(ADDR_CSTAT):  reg_rdata_o = cstat_w;
      AW'(ADDR_CMASK):  reg_rdata_o = cmask_w;
      AW'(ADDR_CAPCTL): reg_rdata_o = DW'(first_ptr);
      AW'(ADDR_DEVSTA): reg_rdata_o = DW'(dev_q);
      default:          reg_rdata_o = '0;
    endcase
  end

  // R5
  unc_msg_has_stat_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (msg_fatal_o || msg_nonfatal_o) |-> (|unc_stat));
  // R8
  fatal_flag_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    msg_fatal_o |-> dev_q[DEV_FATAL]);
  // R8
  cor_flag_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    msg_cor_o |-> dev_q[DEV_COR]);
  // R6
  cor_msg_cause_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    msg_cor_o |-> (|cor_stat));

endmodule

// File: tb/err_log_regs_test.sv
`timescale 1ns/1ps
module err_log_regs_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] ue;
  logic [5:0]  ce;
  logic [2:0]  addr;
  logic [31:0] wd;
  logic        we;
  logic [31:0] rdata;
  logic        m_cor, m_nf, m_fat;

  always #5 clk = ~clk;

  err_log_regs uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .unc_err_i      (ue),
    .cor_err_i      (ce),
    .reg_addr_i     (addr),
    .reg_wdata_i    (wd),
    .reg_we_i       (we),
    .reg_rdata_o    (rdata),
    .msg_cor_o      (m_cor),
    .msg_nonfatal_o (m_nf),
    .msg_fatal_o    (m_fat)
  );

  int nchk = 0;
  int nfail = 0;
  bit mon_en = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model
  int upos[12] = '{4, 5, 12, 13, 14, 15, 16, 17, 18, 19, 20, 21};
  int cpos[6]  = '{0, 6, 7, 8, 12, 13};
  localparam logic [31:0] UIMP = 32'h003F_F030;
  localparam logic [31:0] CIMP = 32'h0000_31C1;

  logic [31:0] r_us, r_um, r_uv, r_cs, r_cm;
  logic [4:0]  r_ptr;
  logic [3:0]  r_dev;
  logic        r_mc, r_mn, r_mf;
  int          rcnt;

  task automatic model_reset();
    r_us = 0; r_um = 0; r_uv = 0; r_cs = 0; r_cm = 32'h2000;
    r_ptr = 0; r_dev = 0; r_mc = 0; r_mn = 0; r_mf = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      model_reset();
      rcnt = 0;
    end else if (rcnt < 2) begin
      model_reset();
      rcnt++;
    end else begin
      logic [31:0] nu, nc;
      nu = 0; nc = 0;
      for (int i = 0; i < 12; i++) if (ue[i] && !r_um[upos[i]]) nu[upos[i]] = 1'b1;
      for (int i = 0; i < 6; i++)  if (ce[i] && !r_cm[cpos[i]]) nc[cpos[i]] = 1'b1;
      if (((r_us & ~r_um) == 0) && (nu != 0)) begin
        for (int b = 31; b >= 0; b--) if (nu[b]) r_ptr = 5'(b);
      end
      r_mc = (nc != 0);
      r_mn = ((nu & ~r_uv) != 0);
      r_mf = ((nu & r_uv) != 0);
      if (we) begin
        case (addr)
          3'd0: r_us = r_us & ~wd;
          3'd1: r_um = wd & UIMP;
          3'd2: r_uv = wd & UIMP;
          3'd3: r_cs = r_cs & ~wd;
          3'd4: r_cm = wd & CIMP;
          3'd6: r_dev = r_dev & ~wd[3:0];
          default: ;
        endcase
      end
      r_us = r_us | nu;
      r_cs = r_cs | nc;
      r_dev = r_dev | {nu[20], r_mf, r_mn, r_mc};
    end
  end

  function automatic logic [31:0] exp_rd(logic [2:0] a);
    case (a)
      3'd0: return r_us;
      3'd1: return r_um;
      3'd2: return r_uv;
      3'd3: return r_cs;
      3'd4: return r_cm;
      3'd5: return {27'b0, r_ptr};
      3'd6: return {28'b0, r_dev};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_for(logic [2:0] a);
    case (a)
      3'd0, 3'd3: return "R3 status vs model";
      3'd5:       return "R7 pointer vs model";
      3'd6:       return "R8 summary vs model";
      default:    return "R9 register vs model";
    endcase
  endfunction

  always @(negedge clk) begin
    if (mon_en) begin
      chk(tag_for(addr), rdata, exp_rd(addr));
      chk("R6 cor msg vs model", {31'b0, m_cor}, {31'b0, r_mc});
      chk("R5 nonfatal msg vs model", {31'b0, m_nf}, {31'b0, r_mn});
      chk("R5 fatal msg vs model", {31'b0, m_fat}, {31'b0, r_mf});
    end
  end

  // one stimulus cycle, then idle; returns at the negedge after capture
  task automatic step(logic [11:0] u, logic [5:0] c, logic w, logic [2:0] a, logic [31:0] d);
    @(posedge clk); #2;
    ue = u; ce = c; we = w; addr = a; wd = d;
    @(posedge clk); #2;
    ue = 0; ce = 0; we = 0;
    @(negedge clk);
  endtask

  task automatic rd(logic [2:0] a, logic [31:0] exp, string tag);
    step(0, 0, 0, a, 0);
    chk(tag, rdata, exp);
  endtask

  bit done = 0;
  initial begin
    #(200000 * 10);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    ue = 0; ce = 0; we = 0; addr = 0; wd = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    mon_en = 1;
    #2 rst_n = 1'b1;
    ue = 12'h001;
    @(posedge clk); #2;
    ue = 0;
    // R10: pulse at the first edge after release is lost
    rd(3'd0, 32'h0, "R10 pulse during reset release");

    // R1 reset values
    rd(3'd1, 32'h0, "R1 unc mask reset");
    rd(3'd2, 32'h0, "R1 severity reset");
    rd(3'd3, 32'h0, "R1 cor status reset");
    rd(3'd4, 32'h2000, "R1 cor mask reset");
    rd(3'd5, 32'h0, "R1 pointer reset");
    rd(3'd6, 32'h0, "R1 summary reset");

    // R2 positions, all sources at once
    step(12'hFFF, 6'h3F, 0, 3'd0, 0);
    chk("R2 unc status positions", rdata, 32'h003F_F030);
    chk("R6 single nonfatal pulse", {31'b0, m_nf}, 32'h1);
    @(negedge clk);
    chk("R6 nonfatal pulse ends", {31'b0, m_nf}, 32'h0);
    rd(3'd3, 32'h0000_11C1, "R2 R4 cor status positions, advisory masked");
    rd(3'd5, 32'd4, "R7 pointer lowest of simultaneous");
    rd(3'd6, 32'hB, "R8 summary cor+nf+ur");

    // R3 write-one-to-clear
    step(0, 0, 1, 3'd0, 32'h0);
    chk("R3 write zero no effect", rdata, 32'h003F_F030);
    step(0, 0, 1, 3'd0, 32'h30);
    chk("R3 write one clears", rdata, 32'h003F_F000);
    step(12'h001, 0, 1, 3'd0, 32'h10);
    chk("R3 set wins over clear", rdata, 32'h003F_F010);
    step(0, 0, 1, 3'd0, 32'hFFFF_FFFF);
    chk("R3 clear all", rdata, 32'h0);
    step(0, 0, 1, 3'd3, 32'hFFFF_FFFF);
    step(0, 0, 1, 3'd6, 32'hFFFF_FFFF);
    chk("R8 summary clear", rdata, 32'h0);

    // R9 read-only and unimplemented
    step(0, 0, 1, 3'd5, 32'hFFFF_FFFF);
    chk("R9 pointer not writable", rdata, 32'd4);
    step(0, 0, 1, 3'd7, 32'hFFFF_FFFF);
    chk("R9 address 7 reads zero", rdata, 32'h0);
    step(0, 0, 1, 3'd1, 32'hFFFF_FFFF);
    chk("R9 mask implemented bits only", rdata, 32'h003F_F030);
    step(0, 0, 1, 3'd1, 32'h2000);

    // R4 masked source 3 (bit 13)
    step(12'h008, 0, 0, 3'd0, 0);
    chk("R4 masked not recorded", rdata, 32'h0);
    chk("R4 masked no message", {30'b0, m_nf, m_fat}, 32'h0);
    step(0, 0, 1, 3'd1, 32'h0);

    // R5 severity on source 4 (bit 14)
    step(0, 0, 1, 3'd2, 32'h4000);
    step(12'h010, 0, 0, 3'd5, 0);
    chk("R5 fatal pulse", {31'b0, m_fat}, 32'h1);
    chk("R5 no nonfatal pulse", {31'b0, m_nf}, 32'h0);
    chk("R7 pointer loads 14", rdata, 32'd14);
    step(12'h004, 0, 0, 3'd5, 0);
    chk("R7 pointer holds", rdata, 32'd14);
    chk("R5 nonfatal for clear severity", {31'b0, m_nf}, 32'h1);
    step(0, 0, 1, 3'd0, 32'hFFFF_FFFF);
    step(12'h208, 0, 0, 3'd5, 0);
    chk("R7 lowest index wins", rdata, 32'd13);
    step(0, 0, 1, 3'd0, 32'hFFFF_FFFF);

    // randomized stretch
    for (int k = 0; k < 600; k++) begin
      logic [11:0] ru;
      logic [5:0]  rc;
      ru = ($urandom % 4 == 0) ? 12'($urandom) : 12'h0;
      rc = ($urandom % 4 == 0) ? 6'($urandom)  : 6'h0;
      step(ru, rc, ($urandom % 3 == 0), 3'($urandom), $urandom);
    end

    // mid-run reset
    @(posedge clk); #2 rst_n = 1'b0;
    #13 rst_n = 1'b1;
    rd(3'd4, 32'h2000, "R1 cor mask after second reset");
    rd(3'd0, 32'h0, "R1 unc status after second reset");

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule